// File: doc/BRIEF.md
# Reversible Gate Primitive Library

A bank of purely combinational reversible gate primitives. Each gate is its own module with as many output lines as input lines. The first input line is carried unchanged to the first output line. No gate drops information except where its defining equation forces it to.

The set holds six gates:

- a 2-line controlled inverter;
- a 3-line doubly controlled inverter;
- a 3-line controlled swap;
- a 3-line doubly controlled inverter followed by a controlled inverter;
- two 4-line gates used when building latches and toggle flip-flops.

The four smaller gates each carry their quantum cost as a constant parameter.

The top module places one instance of each gate side by side on separate ports, so the whole library can be elaborated and exercised as one unit. In every vector, bit 0 is the first line (A in, P out), bit 1 the second (B/Q), bit 2 the third (C/R) and bit 3 the fourth (D/S). No timing is modelled.

Top module: `rev_gate_bank`

## Requirements
- R1: Controlled inverter (2 lines): P = A and Q = A xor B, with quantum cost 1.
- R2: Doubly controlled inverter (3 lines): P = A, Q = B and R = (A and B) xor C, with quantum cost 5.
- R3: Controlled swap (3 lines): P = A, Q = A·C xor A'·B and R = A·B xor A'·C, with quantum cost 5. When A is 1, B and C appear swapped on Q and R.
- R4: Inverter-pair gate (3 lines): P = A, Q = A xor B and R = A·B xor C, with quantum cost 4.
- R5: First 4-line gate: P = A, Q = A'·B xor A·C, R = Q xor D and S = A·B xor A'·C xor D.
- R6: Second 4-line gate: P = A, Q = B'·C xor A'·B xor A·B'·C, R = Q xor D and S = A'·C xor A·B.
- R7: In every gate, the first output line (bit 0) equals the first input line for all input patterns.
- R8: The gates of R1 to R5 are one-to-one. Over all 2^N inputs, each gate produces 2^N distinct output vectors, and its inverse applied to the outputs recovers the inputs.
- R9: The second 4-line gate is implemented exactly as its equations state, and it is not one-to-one. Whenever A is 1, Q is 0. Over all 16 inputs it produces exactly 10 distinct output vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cnot_i | input | 2 | Controlled inverter inputs {B,A} |
| cnot_o | output | 2 | Controlled inverter outputs {Q,P} |
| ccnot_i | input | 3 | Doubly controlled inverter inputs {C,B,A} |
| ccnot_o | output | 3 | Doubly controlled inverter outputs {R,Q,P} |
| cswap_i | input | 3 | Controlled swap inputs {C,B,A} |
| cswap_o | output | 3 | Controlled swap outputs {R,Q,P} |
| pair_i | input | 3 | Inverter-pair gate inputs {C,B,A} |
| pair_o | output | 3 | Inverter-pair gate outputs {R,Q,P} |
| swx4_i | input | 4 | First 4-line gate inputs {D,C,B,A} |
| swx4_o | output | 4 | First 4-line gate outputs {S,R,Q,P} |
| mix4_i | input | 4 | Second 4-line gate inputs {D,C,B,A} |
| mix4_o | output | 4 | Second 4-line gate outputs {S,R,Q,P} |

## Verification
The in-module checks apply each gate's inverse to the outputs that the same evaluation has just produced. They therefore assume the inputs hold known 0/1 values; an unknown line would make the inverse comparison meaningless. The stimulus drives only defined values. It sweeps a 4-bit pattern through all 16 values and slices it onto every gate, so each gate sees every pattern of its own width, and it holds each pattern stable while the outputs are sampled.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int unsigned QC_CNOT  = 1;
  localparam int unsigned QC_CCNOT = 5;
  localparam int unsigned QC_CSWAP = 5;
  localparam int unsigned QC_PAIR  = 4;

  typedef logic [1:0] line2_t;
  typedef logic [2:0] line3_t;
  typedef logic [3:0] line4_t;
endpackage

// File: rtl/rg_cnot.sv
module rg_cnot
  import rg_pkg::*;
#(
  parameter int unsigned QCOST = QC_CNOT
) (
  input  line2_t in_i,
  output line2_t out_o
);
  line2_t o;
  always_comb begin
    o[0] = in_i[0];
    o[1] = in_i[0] ^ in_i[1];
    out_o = o;
    // self-inverse: applying again must give the inputs back
    assert_cnot_inv_R1: assert ({o[1] ^ o[0], o[0]} == in_i)
      else $error("cnot inverse mismatch");
  end
endmodule

// File: rtl/rg_ccnot.sv
module rg_ccnot
  import rg_pkg::*;
#(
  parameter int unsigned QCOST = QC_CCNOT
) (
  input  line3_t in_i,
  output line3_t out_o
);
  line3_t o;
  always_comb begin
    o[0] = in_i[0];
    o[1] = in_i[1];
    o[2] = (in_i[0] & in_i[1]) ^ in_i[2];
    out_o = o;
    assert_ccnot_inv_R2: assert ({(o[0] & o[1]) ^ o[2], o[1], o[0]} == in_i)
      else $error("ccnot inverse mismatch");
  end
endmodule

// File: rtl/rg_cswap.sv
module rg_cswap
  import rg_pkg::*;
#(
  parameter int unsigned QCOST = QC_CSWAP
) (
  input  line3_t in_i,
  output line3_t out_o
);
  logic a, b, c;
  line3_t o, back;
  always_comb begin
    a = in_i[0];
    b = in_i[1];
    c = in_i[2];
    o[0] = a;
    o[1] = (a & c) ^ (~a & b);
    o[2] = (a & b) ^ (~a & c);
    out_o = o;
    back = o[0] ? {o[1], o[2], o[0]} : o;
    assert_cswap_inv_R3: assert (back == in_i)
      else $error("cswap inverse mismatch");
  end
endmodule

// File: rtl/rg_pair.sv
module rg_pair
  import rg_pkg::*;
#(
  parameter int unsigned QCOST = QC_PAIR
) (
  input  line3_t in_i,
  output line3_t out_o
);
  line3_t o;
  logic   b_rec;
  always_comb begin
    o[0] = in_i[0];
    o[1] = in_i[0] ^ in_i[1];
    o[2] = (in_i[0] & in_i[1]) ^ in_i[2];
    out_o = o;
    b_rec = o[0] ^ o[1];
    assert_pair_inv_R4: assert ({(o[0] & b_rec) ^ o[2], b_rec, o[0]} == in_i)
      else $error("pair inverse mismatch");
  end
endmodule

// File: rtl/rg_swx4.sv
module rg_swx4
  import rg_pkg::*;
(
  input  line4_t in_i,
  output line4_t out_o
);
  logic a, b, c, d, d_rec, t_rec;
  line4_t o, back;
  always_comb begin
    a = in_i[0];
    b = in_i[1];
    c = in_i[2];
    d = in_i[3];
    o[0] = a;
    o[1] = (~a & b) ^ (a & c);
    o[2] = (~a & b) ^ (a & c) ^ d;
    o[3] = (a & b) ^ (~a & c) ^ d;
    out_o = o;
    d_rec = o[1] ^ o[2];
    t_rec = o[3] ^ d_rec;
    back  = o[0] ? {d_rec, o[1], t_rec, o[0]} : {d_rec, t_rec, o[1], o[0]};
    assert_swx4_inv_R5: assert (back == in_i)
      else $error("swx4 inverse mismatch");
  end
endmodule

// File: rtl/rg_mix4.sv
module rg_mix4
  import rg_pkg::*;
(
  input  line4_t in_i,
  output line4_t out_o
);
  logic a, b, c, d;
  line4_t o;
  always_comb begin
    a = in_i[0];
    b = in_i[1];
    c = in_i[2];
    d = in_i[3];
    o[0] = a;
    o[1] = (~b & c) ^ (~a & b) ^ (a & ~b & c);
    o[2] = o[1] ^ d;
    o[3] = (~a & c) ^ (a & b);
    out_o = o;
    // with the control line high the second line collapses to zero
    assert_mix4_lock_R9: assert (!o[0] || (o[1] == 1'b0 && o[2] == d && o[3] == b))
      else $error("mix4 control-high collapse violated");
  end
endmodule

// File: rtl/rev_gate_bank.sv
module rev_gate_bank
  import rg_pkg::*;
(
  input  logic [1:0] cnot_i,
  output logic [1:0] cnot_o,
  input  logic [2:0] ccnot_i,
  output logic [2:0] ccnot_o,
  input  logic [2:0] cswap_i,
  output logic [2:0] cswap_o,
  input  logic [2:0] pair_i,
  output logic [2:0] pair_o,
  input  logic [3:0] swx4_i,
  output logic [3:0] swx4_o,
  input  logic [3:0] mix4_i,
  output logic [3:0] mix4_o
);
  rg_cnot  u_cnot  (.in_i(cnot_i),  .out_o(cnot_o));
  rg_ccnot u_ccnot (.in_i(ccnot_i), .out_o(ccnot_o));
  rg_cswap u_cswap (.in_i(cswap_i), .out_o(cswap_o));
  rg_pair  u_pair  (.in_i(pair_i),  .out_o(pair_o));
  rg_swx4  u_swx4  (.in_i(swx4_i),  .out_o(swx4_o));
  rg_mix4  u_mix4  (.in_i(mix4_i),  .out_o(mix4_o));

  always_comb begin
    assert_bank_pass_R7: assert (cnot_o[0] == cnot_i[0] && ccnot_o[0] == ccnot_i[0]
                                 && cswap_o[0] == cswap_i[0] && pair_o[0] == pair_i[0]
                                 && swx4_o[0] == swx4_i[0] && mix4_o[0] == mix4_i[0])
      else $error("first line not carried through");
  end
endmodule

// File: tb/tb_rev_gate_bank.sv
`timescale 1ns/1ps
module tb_rev_gate_bank;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] cnot_i, cnot_o;
  logic [2:0] ccnot_i, ccnot_o, cswap_i, cswap_o, pair_i, pair_o;
  logic [3:0] swx4_i, swx4_o, mix4_i, mix4_o;

  rev_gate_bank dut (
    .cnot_i, .cnot_o, .ccnot_i, .ccnot_o, .cswap_i, .cswap_o,
    .pair_i, .pair_o, .swx4_i, .swx4_o, .mix4_i, .mix4_o
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit seen [6][16];

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // behavioural models, one line at a time
  function automatic logic [3:0] ref_gate(input int g, input logic [3:0] v);
    logic a, b, c, d, q, r, s;
    a = v[0]; b = v[1]; c = v[2]; d = v[3];
    q = 0; r = 0; s = 0;
    case (g)
      0: q = (a != b);
      1: begin q = b; r = (a && b) ? ~c : c; end
      2: begin q = a ? c : b; r = a ? b : c; end
      3: begin q = (a != b); r = (a && b) ? ~c : c; end
      4: begin q = a ? c : b; s = (a ? b : c) ^ d; r = q ^ d; end
      default: begin
        if (a) begin q = 0; s = b; end
        else   begin q = b | c; s = c; end
        r = q ^ d;
      end
    endcase
    return {s, r, q, a};
  endfunction

  function automatic int width_of(input int g);
    return (g == 0) ? 2 : (g < 4) ? 3 : 4;
  endfunction

  function automatic string tag_of(input int g);
    case (g)
      0: return "R1"; 1: return "R2"; 2: return "R3";
      3: return "R4"; 4: return "R5"; default: return "R6";
    endcase
  endfunction

  function automatic logic [3:0] out_of(input int g);
    case (g)
      0: return {2'b0, cnot_o};  1: return {1'b0, ccnot_o};
      2: return {1'b0, cswap_o}; 3: return {1'b0, pair_o};
      4: return swx4_o;          default: return mix4_o;
    endcase
  endfunction

  task automatic drive(input logic [3:0] v);
    cnot_i = v[1:0]; ccnot_i = v[2:0]; cswap_i = v[2:0];
    pair_i = v[2:0]; swx4_i = v; mix4_i = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    drive(4'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset-time idle state with all-zero inputs: R7 plus zero outputs
    for (int g = 0; g < 6; g++) chk("R7 idle", out_of(g), 4'h0);
    rst_ni = 1'b1;

    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 16; k++) begin
        logic [3:0] v;
        v = pass == 0 ? k[3:0] : ~k[3:0];
        @(posedge clk); #1 drive(v);
        @(negedge clk);
        for (int g = 0; g < 6; g++) begin
          logic [3:0] m, e, o;
          m = v & ((4'h1 << width_of(g)) - 4'h1);
          e = ref_gate(g, m);
          o = out_of(g);
          chk(tag_of(g), o, e);
          chk("R7", {3'b0, o[0]}, {3'b0, m[0]});
          seen[g][o] = 1'b1;
        end
        if (v[0]) chk("R9 Q low", {3'b0, mix4_o[1]}, 4'h0);
      end
    end

    // bijectivity census
    for (int g = 0; g < 6; g++) begin
      int n;
      n = 0;
      for (int x = 0; x < 16; x++) if (seen[g][x]) n++;
      if (g < 5) chk($sformatf("R8 image size gate %0d", g), n[3:0] + 4'(n == 16 ? 0 : 0),
                     4'((1 << width_of(g)) & 15));
      else begin
        chk("R9 image size", n[3:0], 4'd10);
        if (n != 16) $display("note: 4-line gate %0d is not one-to-one (%0d images)", g, n);
      end
      if (g == 4 && n != 16) $display("note: 4-line gate %0d is not one-to-one (%0d images)", g, n);
    end
    finish_run();
  end
endmodule